// File: doc/BRIEF.md
# Serial Audio Receiver

The block takes a three-wire serial audio stream (bit clock, word clock, serial data) from an external transmitter. It recovers parallel samples without clocking any logic from the external bit clock. All three lines are brought into the local system clock domain through synchronisers. Edges of the bit clock and the word clock are then found by comparing consecutive synchronised values. The transmitter is assumed to change data and word clock on the falling bit-clock edge. The system clock must run at least four times faster than the bit clock.

Each half-period of the word clock carries one word, most significant bit first, with no padding bits. When the block sees a word-clock transition, it delivers the word that has just ended on a parallel bus. Along with it come a channel flag and a one-cycle valid pulse. A polarity input inverts the word clock before the channel is assigned, which covers both the I2S and left-justified conventions. A second input chooses whether bits are taken when a rising or a falling bit-clock edge is detected. Falling-edge capture uses the data value that was held just before the edge, so polling latency cannot expose changed data.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_ni` is low and right after it is released, `sample_o`, `chan_o`, `valid_o` and `ovf_o` are all 0.
- R2: With `cap_fall_i` = 0, bits are taken at each detected rising bit-clock edge. A word of exactly WORD_W bits appears on `sample_o` with its first-sent bit at bit WORD_W-1.
- R3: Bits beyond WORD_W within one word-clock phase are dropped. `ovf_o` then goes to 1 and stays 1 until reset.
- R4: A word of fewer than WORD_W bits is delivered left-aligned, and the unused low bits are 0.
- R5: `chan_o` equals the word-clock level during the delivered word XOR `ws_inv_i` (0 = left, 1 = right).
- R6: With `cap_fall_i` = 1, each detected falling bit-clock edge captures the data value held just before it. The falling edge that coincides with the word-clock transition contributes the last bit of the word that is ending.
- R7: After reset, the word that ends at the first word-clock transition is not reported.
- R8: `valid_o` is high for exactly one cycle per word-clock transition after the first one. `sample_o` changes only in a cycle where `valid_o` is high.
- R9: `valid_o` rises in the third system-clock cycle after the word-clock input changes (two synchroniser stages plus one output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | External serial bit clock |
| ws_i | input | 1 | External word (channel) clock |
| sd_i | input | 1 | External serial data |
| ws_inv_i | input | 1 | 1 inverts the word clock before channel assignment |
| cap_fall_i | input | 1 | 0 = capture on rising bit-clock edge, 1 = on falling edge |
| sample_o | output | WORD_W | Last completed word, left-aligned |
| chan_o | output | 1 | Channel of `sample_o`, 0 = left, 1 = right |
| valid_o | output | 1 | One-cycle pulse when a new word is presented |
| ovf_o | output | 1 | Sticky flag: a word had more than WORD_W bits |

## Verification
In falling-edge mode, the word-clock transition and the capture of the ending word's last bit are detected in the same system cycle. In that cycle the word is also flushed. The bench drives data and word clock together at each falling bit-clock edge, and it compares every delivered word against the bit pattern it sent. A 17-bit word in that mode makes the overflow drop land in that same flush cycle, so the bench checks that `ovf_o` is already set in the cycle where `valid_o` reports that word.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned SAR_LINES = 3;

  typedef struct packed {
    logic sck;
    logic ws;
    logic sd;
  } sar_lines_t;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sar_dly.sv
module sar_dly #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/sar_deser.sv
module sar_deser #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              bit_i,
  input  logic              flush_i,
  input  logic              chan_i,
  output logic [WORD_W-1:0] sample_o,
  output logic              chan_o,
  output logic              valid_o,
  output logic              ovf_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg_q, word_nx, aligned;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic              seen_q, room, ovf_hit;

  assign room    = cnt_q < CNT_FULL;
  assign ovf_hit = cap_i && !room && seen_q;

  always_comb begin
    word_nx = shreg_q;
    cnt_nx  = cnt_q;
    if (cap_i && room) begin
      word_nx = {shreg_q[WORD_W-2:0], bit_i};
      cnt_nx  = cnt_q + 1'b1;
    end
  end

  // short words are left-aligned; an empty word shifts out to zero
  assign aligned = word_nx << (CNT_FULL - cnt_nx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      seen_q   <= 1'b0;
      sample_o <= '0;
      chan_o   <= 1'b0;
      valid_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (ovf_hit) ovf_o <= 1'b1;
      if (flush_i) begin
        if (seen_q) begin
          sample_o <= aligned;
          chan_o   <= chan_i;
          valid_o  <= 1'b1;
        end
        seen_q  <= 1'b1;
        shreg_q <= '0;
        cnt_q   <= '0;
      end else begin
        shreg_q <= word_nx;
        cnt_q   <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic              ws_inv_i,
  input  logic              cap_fall_i,
  output logic [WORD_W-1:0] sample_o,
  output logic              chan_o,
  output logic              valid_o,
  output logic              ovf_o
);
  sar_lines_t raw, syn, prv;
  logic sck_rise, sck_fall, ws_edge, cap, cap_bit, chan;

  assign raw.sck = sck_i;
  assign raw.ws  = ws_i;
  assign raw.sd  = sd_i;

  sar_sync #(.WIDTH(SAR_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  sar_dly #(.WIDTH(SAR_LINES)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (syn),
    .q_o   (prv)
  );

  assign sck_rise = syn.sck & ~prv.sck;
  assign sck_fall = ~syn.sck & prv.sck;
  assign ws_edge  = syn.ws ^ prv.ws;

  // falling-edge mode takes the value held before the edge
  assign cap     = cap_fall_i ? sck_fall : sck_rise;
  assign cap_bit = cap_fall_i ? prv.sd : syn.sd;
  assign chan    = prv.ws ^ ws_inv_i;

  sar_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .bit_i   (cap_bit),
    .flush_i (ws_edge),
    .chan_i  (chan),
    .sample_o(sample_o),
    .chan_o  (chan_o),
    .valid_o (valid_o),
    .ovf_o   (ovf_o)
  );
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ws_edge_i,
  input logic              valid_i,
  input logic              ovf_i,
  input logic [WORD_W-1:0] sample_i
);
  logic [1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           edges_q <= '0;
    else if (ws_edge_i && edges_q != 2'd2) edges_q <= edges_q + 2'd1;
  end

  p_valid_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(ws_edge_i));

  p_single_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_sample_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_i) |-> valid_i);

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);

  p_first_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> edges_q == 2'd2);
endmodule

bind serial_audio_rx sar_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ws_edge_i(ws_edge),
  .valid_i  (valid_o),
  .ovf_i    (ovf_o),
  .sample_i (sample_o)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
  localparam int W    = 16;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n, sck, ws, sd, ws_inv, cap_fall;
  logic [W-1:0] sample;
  logic chan, valid, ovf;

  int checks = 0, failures = 0, cyc = 0, ws_age = 0, n_valid = 0, n_push = 0;
  logic exp_ovf;
  logic [W-1:0] q_s[$];
  logic         q_c[$];
  logic         q_o[$];
  string        q_t[$];

  always #10 clk = ~clk;

  serial_audio_rx #(.WORD_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .ws_inv_i(ws_inv), .cap_fall_i(cap_fall),
    .sample_o(sample), .chan_o(chan), .valid_o(valid), .ovf_o(ovf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_word(input logic [31:0] bits, input int n);
    logic [31:0] v;
    if (n < 32) bits = bits & ((32'h1 << n) - 32'h1);
    if (n >= W) v = bits >> (n - W);
    else        v = bits << (W - n);
    return v[W-1:0];
  endfunction

  always @(posedge clk) begin
    cyc++;
    ws_age++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && valid) begin
      n_valid++;
      if (q_s.size() == 0) check("R7 R8 unexpected valid", 32'd1, 32'd0);
      else begin
        automatic string t = q_t.pop_front();
        check({t, " sample"}, 32'(sample), 32'(q_s.pop_front()));
        check("R5 chan", 32'(chan), 32'(q_c.pop_front()));
        check("R3 ovf at valid", 32'(ovf), 32'(q_o.pop_front()));
        check("R9 latency", ws_age, 3);
      end
    end
  end

  task automatic send_word(input logic lvl, input logic [31:0] bits, input int n, input string tag);
    logic started = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sck = 1'b0;
      if (i == 0 && ws !== lvl) begin
        ws = lvl;
        ws_age = 0;
        started = 1'b1;
      end
      sd = bits[n-1-i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
    if (started) begin
      if (n > W) exp_ovf = 1'b1;
      q_s.push_back(exp_word(bits, n));
      q_c.push_back(lvl ^ ws_inv);
      q_o.push_back(exp_ovf);
      q_t.push_back(tag);
      n_push++;
    end
  endtask

  task automatic close_stream(input logic lvl);
    @(negedge clk);
    sck = 1'b0;
    ws = lvl;
    ws_age = 0;
    sd = 1'b0;
    repeat (8) @(negedge clk);
    check("R8 all words delivered", 32'(q_s.size()), 32'd0);
    check("R8 valid count", n_valid, n_push);
  endtask

  task automatic do_reset(input logic inv, input logic capf);
    @(negedge clk);
    rst_n = 1'b0;
    sck = 1'b0; ws = 1'b0; sd = 1'b0;
    ws_inv = inv; cap_fall = capf;
    exp_ovf = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(valid), 32'd0);
    check("R1 ovf in reset", 32'(ovf), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sample after reset", 32'(sample), 32'd0);
    check("R1 chan after reset", 32'(chan), 32'd0);
    check("R1 ovf after reset", 32'(ovf), 32'd0);
  endtask

  initial begin
    logic lvl;
    void'($urandom(32'd1234));
    rst_n = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0; ws_inv = 1'b0; cap_fall = 1'b0;
    exp_ovf = 1'b0;

    // rising capture, I2S polarity
    do_reset(1'b0, 1'b0);
    send_word(1'b0, $urandom, 5, "R7");
    send_word(1'b1, $urandom, W, "R2");
    check("R7 first partial word suppressed", n_valid, 0);
    lvl = 1'b0;
    for (int k = 0; k < 6; k++) begin
      send_word(lvl, $urandom, W, "R2");
      lvl = ~lvl;
    end
    send_word(lvl, 32'h0000_01ff, 9, "R4");
    lvl = ~lvl;
    send_word(lvl, 32'h0000_8001, W, "R2");
    close_stream(~lvl);

    // falling capture, inverted polarity, overflow landing on the flush cycle
    do_reset(1'b1, 1'b1);
    send_word(1'b0, $urandom, 3, "R7");
    lvl = 1'b1;
    for (int k = 0; k < 6; k++) begin
      send_word(lvl, $urandom, W, "R6");
      lvl = ~lvl;
    end
    check("R3 ovf clear before long word", 32'(ovf), 32'd0);
    send_word(lvl, 32'h0001_5a5b, W + 1, "R3 R6");
    lvl = ~lvl;
    for (int k = 0; k < 3; k++) begin
      send_word(lvl, $urandom, W, "R3");
      lvl = ~lvl;
    end
    send_word(lvl, $urandom, W + 4, "R3");
    lvl = ~lvl;
    close_stream(lvl);
    check("R3 ovf sticky", 32'(ovf), 32'd1);

    // falling capture, random lengths incl. single bit
    do_reset(1'b0, 1'b1);
    check("R3 ovf cleared by reset", 32'(ovf), 32'd0);
    send_word(1'b0, 32'h5, 3, "R7");
    send_word(1'b1, 32'h1, 1, "R4 R6");
    send_word(1'b0, 32'h2, 2, "R4 R6");
    lvl = 1'b1;
    for (int k = 0; k < 10; k++) begin
      send_word(lvl, $urandom, 1 + int'($urandom % W), "R4 R6");
      lvl = ~lvl;
    end
    close_stream(lvl);

    // rising capture, inverted polarity, random lengths
    do_reset(1'b1, 1'b0);
    send_word(1'b0, $urandom, 7, "R7");
    lvl = 1'b1;
    for (int k = 0; k < 10; k++) begin
      send_word(lvl, $urandom, 1 + int'($urandom % W), "R4 R5");
      lvl = ~lvl;
    end
    close_stream(lvl);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule